// File: doc/BRIEF.md
# Timekeeping Divider with Rate-Select Taps

This block divides a 32.768 kHz time-base enable through a 15-stage binary chain. It produces three things: a once-per-second update strobe for the calendar logic, a square-wave output, and a periodic-interrupt flag. A three-bit chain-control field picks one of three states: the chain counts, the chain is held at zero while the oscillator stays enabled, or the oscillator is gated off so the chain keeps its value. Only one exact pattern lets time run. When that pattern is written from any other state, the chain is preset to its midpoint, so the first update strobe arrives half a second later.

A four-bit rate code picks one of 13 chain taps, or none. The chosen tap can drive the square-wave output, the interrupt flag, both at the same rate, or neither, under two independent enables. All control fields are loaded together by a single write strobe and can be read back. The rate code keeps its value through reset.

Top module: `rtc_rate_divider`

## Requirements
- R1: With chain control 3'b010 the chain advances by one on each cycle where `tick_en` is high and holds on cycles where it is low, so the selected tap toggles at its listed rate.
- R2: With chain control 3'b110 or 3'b111 the chain is held at zero: the square-wave output and interrupt flag stay low and no update strobe occurs.
- R3: Chain control patterns 3'b000, 3'b001, 3'b011, 3'b100 and 3'b101 freeze the chain at its current value: the square-wave output does not change and no update strobe occurs.
- R4: Writing 3'b010 when the control field holds any other pattern presets the chain to half scale. The first `sec_strobe` then comes 16384 time-base ticks after the write edge, and the strobe repeats every 32768 ticks after that. Each strobe is a one-cycle pulse. Writing 3'b010 while already running does not preset the chain.
- R5: Rate code 0 selects no tap. Code 1 gives 256 Hz and code 2 gives 128 Hz. Codes 3 through 15 give 8192 Hz down to 2 Hz, halving at each step. Each frequency assumes a 32768 Hz tick rate, and the tap output is high for half of each period.
- R6: `sq_out` follows the selected tap one cycle later when the square-wave enable is set and the rate code is nonzero. Otherwise it is driven low.
- R7: When the interrupt enable is set and the rate code is nonzero, `irq_flag` sets on each rising edge of the selected tap. It then stays set until a cycle with `irq_ack` high clears it. A new edge in the same cycle as `irq_ack` wins over the clear.
- R8: The square-wave enable and the interrupt enable act independently: either output can run at the selected rate while the other is off.
- R9: A synchronous reset clears the chain control field to 3'b000, clears both enables, the flag, the strobe and the square-wave output, and leaves the rate code unchanged.
- R10: A cycle with `ctl_wr` high loads all four control fields at once, and `dv_q` and `rate_q` return the stored chain control and rate code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 32.768 kHz time-base enable, one cycle per tick |
| ctl_wr | input | 1 | Loads all control fields this cycle |
| ctl_dv | input | 3 | Chain control pattern to write |
| ctl_rate | input | 4 | Rate code to write |
| ctl_sq_en | input | 1 | Square-wave enable to write |
| ctl_irq_en | input | 1 | Periodic-interrupt enable to write |
| irq_ack | input | 1 | Clears the interrupt flag (read side effect) |
| dv_q | output | 3 | Stored chain control pattern |
| rate_q | output | 4 | Stored rate code |
| sq_out | output | 1 | Square-wave output |
| irq_flag | output | 1 | Periodic-interrupt flag |
| sec_strobe | output | 1 | One-cycle update strobe, once per second |

## Verification
The tap selector is driven with five rate codes whose tap periods range from 4 to 16384 ticks. Counting rising edges over a whole number of periods tells a correct tap apart from its neighbours and also catches a swapped special pair. Rate code zero and each single enable are tried, which separates a gated output from a dead tap. Every chain-control pattern is written, plus a run with the tick held low, to separate hold-at-zero, freeze and run. A scoreboard predicts each update strobe from the write cycle, so a missing half-scale preset, a reload on a repeated run write, or a strobe during a freeze each show up as a mistimed or unexpected pulse.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

  localparam int DV_W = 3;
  localparam logic [DV_W-1:0] DV_RUN = 3'b010;

  typedef enum logic [1:0] {
    CHAIN_STOP = 2'd0,
    CHAIN_HOLD = 2'd1,
    CHAIN_RUN  = 2'd2
  } chain_mode_e;

  // Only the exact run pattern counts; 11x holds the chain at zero; the rest freeze it.
  function automatic chain_mode_e decode_dv(input logic [DV_W-1:0] dv);
    if (dv == DV_RUN) return CHAIN_RUN;
    if (dv[2:1] == 2'b11) return CHAIN_HOLD;
    return CHAIN_STOP;
  endfunction

  // Chain bit driven by a nonzero rate code (code 0 selects nothing).
  function automatic int tap_index(input int code);
    if (code == 1) return 6;
    if (code == 2) return 7;
    return code - 2;
  endfunction

endpackage

// File: rtl/rtc_div_ctrl.sv
module rtc_div_ctrl
  import rtc_div_pkg::*;
#(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DV_W-1:0]   dv_in,
  input  logic [RATE_W-1:0] rate_in,
  input  logic              sq_en_in,
  input  logic              irq_en_in,
  output logic [DV_W-1:0]   dv_q,
  output logic [RATE_W-1:0] rate_q,
  output logic              sq_en,
  output logic              irq_en,
  output chain_mode_e       mode,
  output logic              load_half
);

  logic [RATE_W-1:0] rate_r = '0;  // power-up value only; reset leaves it alone

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q   <= '0;
      sq_en  <= 1'b0;
      irq_en <= 1'b0;
    end else if (wr) begin
      dv_q   <= dv_in;
      sq_en  <= sq_en_in;
      irq_en <= irq_en_in;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) rate_r <= rate_in;
  end

  assign rate_q    = rate_r;
  assign mode      = decode_dv(dv_q);
  assign load_half = wr && !rst && (dv_in == DV_RUN) && (dv_q != DV_RUN);

  // R9: reset clears control pattern and enables
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (dv_q == '0 && !sq_en && !irq_en));

  // R10: a write is visible at the readback port on the next cycle
  a_r10_readback: assert property (@(posedge clk) disable iff (rst)
    wr |=> (rate_q == $past(rate_in) && dv_q == $past(dv_in)));

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_div_pkg::*;
#(
  parameter int DIV_BITS = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  chain_mode_e         mode,
  input  logic                load_half,
  output logic [DIV_BITS-1:0] cnt,
  output logic                sec_strobe
);

  localparam logic [DIV_BITS-1:0] HALF = DIV_BITS'(1) << (DIV_BITS - 1);

  always_ff @(posedge clk) begin
    sec_strobe <= 1'b0;
    if (rst) begin
      cnt <= '0;
    end else if (load_half) begin
      cnt <= HALF;
    end else begin
      unique case (mode)
        CHAIN_HOLD: cnt <= '0;
        CHAIN_RUN: if (tick_en) begin
          cnt        <= cnt + 1'b1;
          sec_strobe <= &cnt;
        end
        default: cnt <= cnt;
      endcase
    end
  end

  // R1: running chain advances one step per tick
  a_r1_advance: assert property (@(posedge clk) disable iff (rst)
    (mode == CHAIN_RUN && tick_en && !load_half) |=> (cnt == $past(cnt) + 1'b1));

  // R2: hold patterns force the chain to zero
  a_r2_chain_zero: assert property (@(posedge clk) disable iff (rst)
    (mode == CHAIN_HOLD && !load_half) |=> (cnt == '0));

  // R3: stop patterns freeze the chain
  a_r3_freeze: assert property (@(posedge clk) disable iff (rst)
    (mode == CHAIN_STOP && !load_half) |=> $stable(cnt));

  // R4: entering run presets half scale; strobe lasts one cycle
  a_r4_half_preset: assert property (@(posedge clk) disable iff (rst)
    load_half |=> (cnt == HALF));
  a_r4_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    sec_strobe |=> !sec_strobe);

endmodule

// File: rtl/rtc_div_tap.sv
module rtc_div_tap
  import rtc_div_pkg::*;
#(
  parameter int DIV_BITS = 15,
  parameter int RATE_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIV_BITS-1:0] cnt,
  input  logic [RATE_W-1:0]   rate,
  input  logic                sq_en,
  input  logic                irq_en,
  input  logic                irq_ack,
  output logic                sq_out,
  output logic                irq_flag
);

  localparam int N_CODES = 2 ** RATE_W;

  logic [N_CODES-1:0] tap_vec;
  logic               tap;
  logic               tap_d;
  logic               rate_on;
  logic               tap_rise;
  logic               unused_ends;

  for (genvar c = 0; c < N_CODES; c++) begin : g_tap
    if (c == 0) begin : g_off
      assign tap_vec[c] = 1'b0;
    end else begin : g_on
      localparam int TB = tap_index(c);
      assign tap_vec[c] = cnt[TB];
    end
  end

  assign unused_ends = ^{cnt[0], cnt[DIV_BITS-1]};
  assign tap      = tap_vec[rate];
  assign rate_on  = |rate;
  assign tap_rise = irq_en && rate_on && tap && !tap_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_d    <= 1'b0;
      sq_out   <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      tap_d  <= tap;
      sq_out <= sq_en && rate_on && tap;
      if (tap_rise)     irq_flag <= 1'b1;
      else if (irq_ack) irq_flag <= 1'b0;
    end
  end

  // R6: output quiet when disabled or no tap selected
  a_r6_sq_quiet: assert property (@(posedge clk) disable iff (rst)
    (!sq_en || rate == '0) |=> !sq_out);

  // R7: flag holds until acknowledged
  a_r7_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_ack) |=> irq_flag);

  // R7: flag never rises while the interrupt enable is clear
  a_r7_no_set_disabled: assert property (@(posedge clk) disable iff (rst)
    (!irq_en && !irq_flag) |=> !irq_flag);

endmodule

// File: rtl/rtc_rate_divider.sv
module rtc_rate_divider
  import rtc_div_pkg::*;
#(
  parameter int DIV_BITS = 15,
  parameter int RATE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_dv,
  input  logic [RATE_W-1:0] ctl_rate,
  input  logic              ctl_sq_en,
  input  logic              ctl_irq_en,
  input  logic              irq_ack,
  output logic [2:0]        dv_q,
  output logic [RATE_W-1:0] rate_q,
  output logic              sq_out,
  output logic              irq_flag,
  output logic              sec_strobe
);

  chain_mode_e         mode;
  logic                load_half;
  logic                sq_en;
  logic                irq_en;
  logic [DIV_BITS-1:0] cnt;

  rtc_div_ctrl #(.RATE_W(RATE_W)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr        (ctl_wr),
    .dv_in     (ctl_dv),
    .rate_in   (ctl_rate),
    .sq_en_in  (ctl_sq_en),
    .irq_en_in (ctl_irq_en),
    .dv_q      (dv_q),
    .rate_q    (rate_q),
    .sq_en     (sq_en),
    .irq_en    (irq_en),
    .mode      (mode),
    .load_half (load_half)
  );

  rtc_div_chain #(.DIV_BITS(DIV_BITS)) i_chain (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .mode       (mode),
    .load_half  (load_half),
    .cnt        (cnt),
    .sec_strobe (sec_strobe)
  );

  rtc_div_tap #(.DIV_BITS(DIV_BITS), .RATE_W(RATE_W)) i_tap (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt),
    .rate     (rate_q),
    .sq_en    (sq_en),
    .irq_en   (irq_en),
    .irq_ack  (irq_ack),
    .sq_out   (sq_out),
    .irq_flag (irq_flag)
  );

endmodule

// File: tb/test_rtc_rate_divider.sv
`timescale 1ns/1ps
module test_rtc_rate_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [2:0] ctl_dv = '0;
  logic [3:0] ctl_rate = '0;
  logic       ctl_sq_en = 1'b0;
  logic       ctl_irq_en = 1'b0;
  logic       irq_ack = 1'b0;
  logic [2:0] dv_q;
  logic [3:0] rate_q;
  logic       sq_out;
  logic       irq_flag;
  logic       sec_strobe;

  int cyc = 0;
  int errs = 0;
  int checks = 0;
  int exp_q[$];
  bit done = 1'b0;

  rtc_rate_divider i_rtc_rate_divider (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ctl_wr(ctl_wr), .ctl_dv(ctl_dv),
    .ctl_rate(ctl_rate), .ctl_sq_en(ctl_sq_en), .ctl_irq_en(ctl_irq_en),
    .irq_ack(irq_ack), .dv_q(dv_q), .rate_q(rate_q), .sq_out(sq_out),
    .irq_flag(irq_flag), .sec_strobe(sec_strobe)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every strobe must match the next predicted cycle (R4)
  always @(negedge clk) begin
    if (!rst && sec_strobe) begin
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected strobe", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R4 strobe cycle", cyc, e);
      end
    end
  end

  task automatic wr(input logic [2:0] dv, input logic [3:0] r, input bit sqe, input bit ie,
                    output int wcyc);
    @(negedge clk);
    ctl_dv = dv; ctl_rate = r; ctl_sq_en = sqe; ctl_irq_en = ie; ctl_wr = 1'b1;
    wcyc = cyc + 1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic set_run(input logic [3:0] r, input bit sqe, input bit ie);
    int w;
    wr(3'b010, r, sqe, ie, w);
    repeat (2) @(negedge clk);
  endtask

  task automatic window(input int n, output int rises, output int toggles, output int irq_hi);
    logic prev;
    prev = sq_out; rises = 0; toggles = 0; irq_hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (sq_out != prev) toggles++;
      if (sq_out && !prev) rises++;
      if (irq_flag) irq_hi++;
      prev = sq_out;
    end
  endtask

  // R5 / R1: tap period check with ack held so each interrupt event is one high cycle
  task automatic freq(input logic [3:0] code, input int period, input int nper, input string req);
    int ri, tg, ih;
    set_run(code, 1'b1, 1'b1);
    irq_ack = 1'b1;
    window(period * nper, ri, tg, ih);
    check(ri == nper, {req, " square-wave rises"}, ri, nper);
    check(ih == nper, {req, " interrupt events"}, ih, nper);
  endtask

  initial begin
    int w, s, w2, ri, tg, ih, waited;
    logic [2:0] stops [5];
    stops[0] = 3'b000; stops[1] = 3'b001; stops[2] = 3'b011; stops[3] = 3'b100; stops[4] = 3'b101;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10: write and read back
    wr(3'b110, 4'd5, 1'b1, 1'b1, w);
    check(dv_q == 3'b110, "R10 dv readback", dv_q, 6);
    check(rate_q == 4'd5, "R10 rate readback", rate_q, 5);

    // R9: reset keeps rate, clears the rest
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(rate_q == 4'd5, "R9 rate kept through reset", rate_q, 5);
    check(dv_q == 3'b000, "R9 dv cleared", dv_q, 0);
    check(sq_out == 1'b0, "R9 sq_out low", sq_out, 0);
    check(irq_flag == 1'b0, "R9 irq_flag low", irq_flag, 0);

    // R2: hold pattern keeps the chain at zero
    wr(3'b110, 4'd3, 1'b1, 1'b1, w);
    repeat (2) @(negedge clk);
    irq_ack = 1'b1;
    window(2000, ri, tg, ih);
    check(tg == 0, "R2 no square-wave activity in hold", tg, 0);
    check(ih == 0, "R2 no interrupt in hold", ih, 0);
    check(sq_out == 1'b0, "R2 chain at zero", sq_out, 0);

    // R4: run entry; predicted strobes pushed by the driver
    wr(3'b010, 4'd3, 1'b1, 1'b1, w);
    exp_q.push_back(w + 16384);
    exp_q.push_back(w + 16384 + 32768);
    exp_q.push_back(w + 16384 + 65536);
    repeat (2) @(negedge clk);

    freq(4'd3, 4, 4, "R1 R5 code 3");
    freq(4'd1, 128, 4, "R5 code 1");
    freq(4'd2, 256, 4, "R5 code 2");
    freq(4'd10, 512, 4, "R5 code 10");
    freq(4'd15, 16384, 2, "R5 code 15");

    // R1: no tick, no advance
    tick_en = 1'b0;
    window(100, ri, tg, ih);
    check(tg == 0, "R1 chain idle without tick", tg, 0);
    tick_en = 1'b1;

    // R5 / R6: code 0 selects nothing
    set_run(4'd0, 1'b1, 1'b1);
    window(1000, ri, tg, ih);
    check(tg == 0 && sq_out == 1'b0, "R6 code 0 square-wave low", tg, 0);
    check(ih == 0, "R5 code 0 no interrupt", ih, 0);

    // R8 / R6: interrupt alone
    set_run(4'd3, 1'b0, 1'b1);
    window(64, ri, tg, ih);
    check(tg == 0 && sq_out == 1'b0, "R6 square-wave disabled", tg, 0);
    check(ih == 16, "R8 interrupt alone", ih, 16);

    // R8: square wave alone
    set_run(4'd3, 1'b1, 1'b0);
    window(64, ri, tg, ih);
    check(ri == 16, "R8 square-wave alone", ri, 16);
    check(ih == 0, "R8 interrupt disabled", ih, 0);

    // R7: sticky flag and acknowledge
    set_run(4'd15, 1'b0, 1'b1);
    irq_ack = 1'b0;
    waited = 0;
    while (!irq_flag && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    check(irq_flag == 1'b1, "R7 flag sets on tap edge", irq_flag, 1);
    repeat (100) @(negedge clk);
    check(irq_flag == 1'b1, "R7 flag held without ack", irq_flag, 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(irq_flag == 1'b0, "R7 ack clears flag", irq_flag, 0);
    @(negedge clk);
    check(irq_flag == 1'b0, "R7 flag stays clear", irq_flag, 0);

    // R3: stop patterns freeze the chain
    wr(3'b000, 4'd3, 1'b1, 1'b1, s);
    while (exp_q.size() > 0 && exp_q[$] > s) void'(exp_q.pop_back());
    foreach (stops[i]) begin
      wr(stops[i], 4'd3, 1'b1, 1'b1, w);
      repeat (2) @(negedge clk);
      window(200, ri, tg, ih);
      check(tg == 0, "R3 chain frozen", tg, 0);
    end

    // R4 / R1: restart presets half scale again
    wr(3'b010, 4'd3, 1'b1, 1'b1, w2);
    exp_q.push_back(w2 + 16384);
    while (cyc < w2 + 16390) @(negedge clk);
    check(exp_q.size() == 0, "R4 all predicted strobes seen", exp_q.size(), 0);
    freq(4'd3, 4, 4, "R1 after restart");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule